// File: doc/BRIEF.md
# Phase Error Qualification Monitor

This block decides whether the reference clock currently driving a phase-locked loop is phase-qualified. Once per phase-compare cycle a strobe arrives with a flag saying whether the measured phase error fell outside its allowed window (about 0.75 ns). Measuring that error is outside the block; only the resulting flag is seen here. The status is meant for the reference failure qualifier.

Losing qualification and regaining it follow different rules. A qualified reference is dropped when more than five of the latest eight compare results were out of window. An unqualified reference is accepted again only after eight compare results in a row within the window. The check concerns only the reference in use: while the active input is low the status reads qualified. Selecting another reference, or becoming active again, restarts the evaluation from an unqualified state with empty history.

Top module: `phase_qual_monitor`

## Requirements
- R1: While reset is asserted and for the first cycle after it, with `active` high, `phase_ok` is 0 (unqualified).
- R2: When qualified, a strobe that makes the count of out-of-window flags among the latest eight strobes (including this one) six or more clears `phase_ok`.
- R3: When unqualified, `phase_ok` becomes 1 only on the eighth consecutive strobe with `over_win` = 0; an out-of-window strobe restarts that run from zero.
- R4: When qualified, a window holding five or fewer out-of-window flags leaves `phase_ok` at 1.
- R5: While `active` is 0, `phase_ok` is 1 and strobes and their flags have no effect on it.
- R6: A change of `ref_sel` between two sampled edges, or `active` going from 0 to 1, clears the history and the good run, so `phase_ok` is 0 after that edge (when `active` is 1) and requalification needs eight fresh good strobes.
- R7: Clock edges without `cmp_strobe` leave `phase_ok` unchanged.
- R8: A strobe sampled at a rising clock edge changes `phase_ok` right after that same edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Compare-domain clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_strobe | input | 1 | One-cycle pulse per phase-compare cycle |
| over_win | input | 1 | Phase error outside the window for this compare cycle, valid with the strobe |
| active | input | 1 | The monitored reference is the one the loop is using |
| ref_sel | input | 1 | Identifier of the monitored reference; a change restarts evaluation |
| phase_ok | output | 1 | 1 = phase-qualified (forced 1 while inactive) |

## Verification
The bench builds the block with its defaults: an eight-strobe window, a drop threshold above five and an eight-strobe good run. That small window makes a complete sweep practical: every one of the 256 eight-strobe flag patterns is played into a freshly qualified reference, putting each drop-or-hold decision at the five/six boundary in reach. A long pseudo-random run that mixes idle cycles, reference switches and inactive spells then checks that restarts and the asymmetric rules interact as a bit-level model of the requirements predicts.

// File: rtl/phase_qual_pkg.sv
package phase_qual_pkg;

  // Number of set bits in a vector of up to 32 bits.
  function automatic int unsigned pq_ones(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) begin
      n += v[i] ? 1 : 0;
    end
    return n;
  endfunction

  // Counter step that stops at a ceiling.
  function automatic int unsigned pq_sat_inc(input int unsigned c, input int unsigned lim);
    return (c >= lim) ? lim : c + 1;
  endfunction

  // Decision for the next qualification status.
  function automatic logic pq_decide(input logic qual, input int unsigned bad_cnt,
                                     input int unsigned bad_limit, input int unsigned run,
                                     input int unsigned run_need);
    logic nxt;
    nxt = qual;
    if (qual && (bad_cnt > bad_limit)) nxt = 1'b0;
    else if (!qual && (run >= run_need)) nxt = 1'b1;
    return nxt;
  endfunction

endpackage

// File: rtl/pq_history.sv
module pq_history
  import phase_qual_pkg::*;
#(
  parameter int WIN_LEN = 8,
  localparam int CNT_W = $clog2(WIN_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               step,
  input  logic               bit_in,
  output logic [WIN_LEN-1:0] hist,
  output logic [CNT_W-1:0]   bad_next
);

  logic [WIN_LEN-1:0] shifted;

  generate
    if (WIN_LEN == 1) begin : g_one
      assign shifted = bit_in;
    end else begin : g_many
      assign shifted = {hist[WIN_LEN-2:0], bit_in};
    end
  endgenerate

  assign bad_next = CNT_W'(pq_ones(32'(shifted)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hist <= '0;
    else if (clr)  hist <= '0;
    else if (step) hist <= shifted;
  end

endmodule

// File: rtl/pq_good_run.sv
module pq_good_run
  import phase_qual_pkg::*;
#(
  parameter int GOOD_RUN = 8,
  localparam int RUN_W = $clog2(GOOD_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             bad,
  output logic [RUN_W-1:0] run,
  output logic [RUN_W-1:0] run_next
);

  always_comb begin
    if (bad) run_next = '0;
    else     run_next = RUN_W'(pq_sat_inc(int'(run), GOOD_RUN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= '0;
    else if (clr)  run <= '0;
    else if (step) run <= run_next;
  end

endmodule

// File: rtl/pq_status.sv
module pq_status
  import phase_qual_pkg::*;
#(
  parameter int WIN_LEN   = 8,
  parameter int BAD_LIMIT = 5,
  parameter int GOOD_RUN  = 8,
  localparam int CNT_W = $clog2(WIN_LEN + 1),
  localparam int RUN_W = $clog2(GOOD_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [CNT_W-1:0] bad_next,
  input  logic [RUN_W-1:0] run_next,
  output logic             qual
);

  logic qual_d;

  assign qual_d = pq_decide(qual, int'(bad_next), BAD_LIMIT, int'(run_next), GOOD_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    qual <= 1'b0;
    else if (clr)  qual <= 1'b0;
    else if (step) qual <= qual_d;
  end

endmodule

// File: rtl/phase_qual_monitor.sv
module phase_qual_monitor #(
  parameter int WIN_LEN   = 8,
  parameter int BAD_LIMIT = 5,
  parameter int GOOD_RUN  = 8,
  localparam int CNT_W = $clog2(WIN_LEN + 1),
  localparam int RUN_W = $clog2(GOOD_RUN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_strobe,
  input  logic over_win,
  input  logic active,
  input  logic ref_sel,
  output logic phase_ok
);

  logic               ref_q;
  logic               active_q;
  logic               restart_evt;
  logic               step_evt;
  logic [WIN_LEN-1:0] hist;
  logic [CNT_W-1:0]   bad_next;
  logic [RUN_W-1:0]   run_now;
  logic [RUN_W-1:0]   run_next;
  logic               qual_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q    <= 1'b0;
      active_q <= 1'b0;
    end else begin
      ref_q    <= ref_sel;
      active_q <= active;
    end
  end

  assign restart_evt = (ref_sel != ref_q) || (active && !active_q);
  assign step_evt    = cmp_strobe && active && !restart_evt;

  pq_history #(.WIN_LEN(WIN_LEN)) u_hist (
    .clk(clk), .rst_n(rst_n), .clr(restart_evt), .step(step_evt),
    .bit_in(over_win), .hist(hist), .bad_next(bad_next)
  );

  pq_good_run #(.GOOD_RUN(GOOD_RUN)) u_run (
    .clk(clk), .rst_n(rst_n), .clr(restart_evt), .step(step_evt),
    .bad(over_win), .run(run_now), .run_next(run_next)
  );

  pq_status #(.WIN_LEN(WIN_LEN), .BAD_LIMIT(BAD_LIMIT), .GOOD_RUN(GOOD_RUN)) u_stat (
    .clk(clk), .rst_n(rst_n), .clr(restart_evt), .step(step_evt),
    .bad_next(bad_next), .run_next(run_next), .qual(qual_r)
  );

  assign phase_ok = active ? qual_r : 1'b1;

endmodule

// File: rtl/phase_qual_checker.sv
module phase_qual_checker #(
  parameter int WIN_LEN   = 8,
  parameter int BAD_LIMIT = 5,
  parameter int GOOD_RUN  = 8,
  localparam int CNT_W = $clog2(WIN_LEN + 1),
  localparam int RUN_W = $clog2(GOOD_RUN + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               active,
  input logic               phase_ok,
  input logic               restart_evt,
  input logic               step_evt,
  input logic               qual_r,
  input logic [WIN_LEN-1:0] hist,
  input logic [CNT_W-1:0]   bad_next,
  input logic [RUN_W-1:0]   run_now,
  input logic [RUN_W-1:0]   run_next
);

  a_r5_inactive_ok: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> phase_ok);

  a_r2_drop_on_excess: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && qual_r && (int'(bad_next) > BAD_LIMIT)) |=> !qual_r);

  a_r4_hold_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && qual_r && (int'(bad_next) <= BAD_LIMIT)) |=> qual_r);

  a_r3_rise_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qual_r) |-> (int'(run_now) >= GOOD_RUN) && (hist == '0));

  a_r3_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run_now) <= GOOD_RUN);

  a_r6_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |=> (!qual_r && (hist == '0) && (run_now == '0)));

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_evt && !restart_evt) |=> ($stable(qual_r) && $stable(hist) && $stable(run_now)));

  a_r3_run_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (run_now == $past(run_next)));

endmodule

bind phase_qual_monitor phase_qual_checker #(
  .WIN_LEN(WIN_LEN), .BAD_LIMIT(BAD_LIMIT), .GOOD_RUN(GOOD_RUN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .phase_ok(phase_ok),
  .restart_evt(restart_evt), .step_evt(step_evt), .qual_r(qual_r),
  .hist(hist), .bad_next(bad_next), .run_now(run_now), .run_next(run_next)
);

// File: tb/phase_qual_monitor_test.sv
module phase_qual_monitor_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_strobe = 1'b0;
  logic over_win = 1'b0;
  logic active = 1'b1;
  logic ref_sel = 1'b0;
  logic phase_ok;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model of the requirements
  int  m_hist = 0;   // latest flag in bit 0
  int  m_run  = 0;
  bit  m_qual = 0;
  bit  m_ref  = 0;
  bit  m_act  = 0;

  always #2.5ns clk = ~clk;

  phase_qual_monitor uut (
    .clk(clk), .rst_n(rst_n), .cmp_strobe(cmp_strobe), .over_win(over_win),
    .active(active), .ref_sel(ref_sel), .phase_ok(phase_ok)
  );

  function automatic int ones8(input int h);
    int n = 0;
    for (int k = 0; k < 8; k++) n += (h >> k) & 1;
    return n;
  endfunction

  task automatic check(input logic exp, input string req);
    checks++;
    if (phase_ok !== exp) begin
      errors++;
      $display("FAIL %s: phase_ok=%b expected=%b at %0t", req, phase_ok, exp, $time);
    end
  endtask

  function automatic void model_edge(input bit stb, input bit ov);
    bit rs;
    rs = (ref_sel != m_ref) || (active && !m_act);
    m_ref = ref_sel;
    m_act = active;
    if (rs) begin
      m_hist = 0; m_run = 0; m_qual = 0;
    end else if (stb && active) begin
      m_hist = (m_hist * 2 + ov) % 256;
      m_run  = ov ? 0 : ((m_run >= 8) ? 8 : m_run + 1);
      if (m_qual && ones8(m_hist) >= 6) m_qual = 0;
      else if (!m_qual && m_run >= 8)   m_qual = 1;
    end
  endfunction

  // Called at a falling edge: drive, pass one rising edge, check at the next falling edge.
  task automatic cyc(input bit stb, input bit ov, input string req);
    cmp_strobe = stb;
    over_win = ov;
    @(posedge clk);
    model_edge(stb, ov);
    @(negedge clk);
    cmp_strobe = 1'b0;
    check(active ? m_qual : 1'b1, req);
  endtask

  task automatic toggle_ref(input string req);
    ref_sel = ~ref_sel;
    cyc(1'b0, 1'b0, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lf;
    bit old;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(1'b0, "R1 in reset");
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, "R1 after reset");

    // R3: seven good strobes are not enough, the eighth is
    for (int i = 0; i < 7; i++) cyc(1'b1, 1'b0, "R3 partial run");
    check(1'b0, "R3 seven good");
    // R8: before the eighth strobe's edge nothing changes
    cmp_strobe = 1'b1; over_win = 1'b0;
    @(posedge clk); #0.5ns;
    model_edge(1'b1, 1'b0);
    cmp_strobe = 1'b0;
    check(1'b1, "R8 right after edge");
    @(negedge clk);
    check(1'b1, "R3 eighth good");

    // R7: idle cycles keep the status
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, "R7 idle");

    // R3: a bad strobe inside the run restarts it
    toggle_ref("R6 ref change");
    for (int i = 0; i < 7; i++) cyc(1'b1, 1'b0, "R3 run");
    cyc(1'b1, 1'b1, "R3 broken run");
    for (int i = 0; i < 7; i++) cyc(1'b1, 1'b0, "R3 rerun");
    check(1'b0, "R3 rerun short");
    cyc(1'b1, 1'b0, "R3 rerun complete");

    // R2 R4: all 256 window patterns into a qualified reference
    for (int p = 0; p < 256; p++) begin
      toggle_ref("R6 sweep restart");
      for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, "R3 sweep qualify");
      for (int b = 7; b >= 0; b--) cyc(1'b1, 1'((p >> b) & 1), "R2 R4 sweep");
      checks++;
      if ((ones8(p) >= 6 ? 1'b0 : 1'b1) !== m_qual || phase_ok !== m_qual) begin
        errors++;
        $display("FAIL R2 R4 pattern %0d: phase_ok=%b expected=%b", p, phase_ok,
                 (ones8(p) >= 6) ? 1'b0 : 1'b1);
      end
    end

    // R5: inactive reports qualified, strobes have no effect
    active = 1'b0;
    cyc(1'b0, 1'b0, "R5 inactive");
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b1, "R5 bad while inactive");
    // R6: becoming active restarts
    active = 1'b1;
    cyc(1'b0, 1'b0, "R6 active again");
    check(1'b0, "R6 unqualified on return");

    // mixed pseudo-random run
    lf = 32'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lf = (lf >> 1) ^ ((lf & 1) ? 32'hB400 : 0);
      old = active;
      if ((lf & 255) == 3) ref_sel = ~ref_sel;
      if ((lf & 255) == 7) active = ~active;
      cyc(1'((lf >> 3) & 1) | 1'((lf >> 9) & 1), ((lf >> 5) & 7) < 3, "R2 R3 R6 R7 mixed");
      if (!old && active) check(1'b0, "R6 mixed reactivation");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule